// File: doc/BRIEF.md
# Synchronous burst read output sequencer

This block is the read-side output path of a burst-capable flash memory model. A start strobe latches a word address. In synchronous mode a programmable initial latency then runs, followed by a stream of 16-bit words taken from a computed array model. The stream carries one word per data cycle, and a data cycle lasts one or two clocks as set by a configuration bit. The burst address advances at the end of each data cycle. It either counts straight through the address space or wraps inside an aligned block of 4, 8 or 16 words.

A WAIT indication tells the host when the data on the bus is not yet valid. WAIT is not driven while the chip is deselected, while output enable is low, or during a write. It is asserted in synchronous reads until data is valid and held low in asynchronous reads. High impedance on WAIT and on the data bus is modelled by active-high drive-enable outputs. A one-clock data-valid pulse marks the first clock of every data cycle. When the select input drops, the burst is abandoned and the sequencer is idle after the next clock.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, the hold setting is two clocks, the initial latency is 3 clocks and the address steps continuously. No data-valid pulse occurs until a burst is started.
- R2: When start_i is high with sel_i and sync_i high at a clock edge, the first word appears and dv_o pulses exactly L clocks after that edge. L is the programmed latency, 2 to 7, and a programmed value of 0 or 1 acts as 2.
- R3: With cfg_hold2_i written as 1, each word stays on dq_o for two clocks and dv_o is high only on the first of them. With 0, each word lasts one clock and dv_o is high on every data clock.
- R4: The address advances by one at the end of each data cycle. Wrap code 0 gives continuous counting modulo the address space. Codes 1, 2 and 3 wrap within the aligned block of 4, 8 and 16 words that holds the start address.
- R5: The word presented for address A is {~A[7:0], A[7:0]}.
- R6: wait_oe_o and dq_oe_o are high only when sel_i and oe_i are high and we_i is low.
- R7: In synchronous mode, while driven, wait_o is high from the start edge until the first word, and also while no burst is active. It is low on every data clock.
- R8: In asynchronous mode (sync_i low), while driven, wait_o is low, dv_o stays low, and dq_o shows the word for addr_i.
- R9: sel_i low at a clock edge ends the burst. dv_o is low after that edge, and no word follows until a new start.
- R10: When dq_oe_o is low, dq_o reads 0. When wait_oe_o is low, wait_o reads 0.
- R11: A start strobe with sync_i low starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, active high |
| oe_i | input | 1 | Output enable request, active high |
| we_i | input | 1 | Write access in progress |
| sync_i | input | 1 | 1 for synchronous burst reads, 0 for asynchronous reads |
| start_i | input | 1 | Address latch strobe |
| addr_i | input | AW | Start address (burst) or read address (asynchronous) |
| cfg_wr_i | input | 1 | Load the configuration fields below |
| cfg_hold2_i | input | 1 | 1 holds each word for two clocks, 0 for one clock |
| cfg_lat_i | input | LAT_W | Initial latency in clocks |
| cfg_wrap_i | input | 2 | Wrap code: 0 continuous, 1 four, 2 eight, 3 sixteen words |
| dq_o | output | 16 | Output data |
| dq_oe_o | output | 1 | Data bus drive enable |
| dv_o | output | 1 | Pulse on the first clock of each data cycle |
| wait_o | output | 1 | WAIT level, high while data is not valid |
| wait_oe_o | output | 1 | WAIT drive enable |

## Verification
The sharpest coincidence is an abort that lands on the edge where the sequencer would otherwise step to the next word. The bench drops sel_i in the middle of a one-clock-hold burst, so the same edge both advances the address and ends the burst. It then requires dv_o to be low and the data and WAIT enables to be off. After select is raised again without a start, it requires an idle, WAIT-asserted state with no words. A second coincidence comes from the sweep of start addresses next to block boundaries: wrap and hold meet where the last clock of a held word is also the wrap point. The bench computes every expected address from the wrap arithmetic.

// File: rtl/brs_pkg.sv
package brs_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LAT  = 2'd1,
      ST_DATA = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      WR_CONT = 2'd0,
      WR_4    = 2'd1,
      WR_8    = 2'd2,
      WR_16   = 2'd3
   } wrap_e;

   // Array model: content is a pure function of the low address byte.
   function automatic logic [WORD_W-1:0] array_word(input logic [7:0] a);
      return {~a, a};
   endfunction

endpackage

// File: rtl/brs_cfg.sv
module brs_cfg #(
   parameter int LAT_W   = 3,
   parameter int LAT_MIN = 2,
   parameter int LAT_RST = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic             hold2_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic [1:0]       wrap_i,
   output logic             hold2_o,
   output logic [LAT_W-1:0] lat_o,
   output logic [1:0]       wrap_o
);
   localparam logic [LAT_W-1:0] LatMinV = LAT_W'(LAT_MIN);
   localparam logic [LAT_W-1:0] LatRstV = LAT_W'(LAT_RST);

   logic [LAT_W-1:0] lat_clamped;

   assign lat_clamped = (lat_i < LatMinV) ? LatMinV : lat_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold2_o <= 1'b1;
         lat_o   <= LatRstV;
         wrap_o  <= 2'd0;
      end else if (wr_i) begin
         hold2_o <= hold2_i;
         lat_o   <= lat_clamped;
         wrap_o  <= wrap_i;
      end
   end
endmodule

// File: rtl/brs_pacer.sv
module brs_pacer
   import brs_pkg::*;
#(
   parameter int LAT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             start_i,
   input  logic             hold2_i,
   input  logic [LAT_W-1:0] lat_i,
   output seq_state_e       state_o,
   output logic             dv_o,
   output logic             step_o
);
   seq_state_e       state_q;
   logic [LAT_W-1:0] cnt_q;
   logic             ph_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ph_q    <= 1'b0;
      end else if (!run_i) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ph_q    <= 1'b0;
      end else if (start_i) begin
         state_q <= ST_LAT;
         cnt_q   <= lat_i - LAT_W'(1);
         ph_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_LAT: begin
               if (cnt_q == '0) begin
                  state_q <= ST_DATA;
                  ph_q    <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - LAT_W'(1);
               end
            end
            ST_DATA: ph_q <= hold2_i && !ph_q;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign dv_o    = (state_q == ST_DATA) && !ph_q;
   assign step_o  = run_i && !start_i && (state_q == ST_DATA) && (!hold2_i || ph_q);
endmodule

// File: rtl/brs_addr.sv
module brs_addr
   import brs_pkg::*;
#(
   parameter int AW      = 8,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [AW-1:0] load_addr_i,
   input  logic          step_i,
   input  logic [1:0]    wrap_i,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] addr_q;
   logic [AW-1:0] mask;
   logic [AW-1:0] addr_next;

   if (WRAP_EN) begin : g_wrap
      always_comb begin
         unique case (wrap_e'(wrap_i))
            WR_4:    mask = AW'(3);
            WR_8:    mask = AW'(7);
            WR_16:   mask = AW'(15);
            default: mask = '1;
         endcase
      end
   end else begin : g_linear
      assign mask = '1;
   end

   assign addr_next = (addr_q & ~mask) | ((addr_q + AW'(1)) & mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      addr_q <= '0;
      else if (load_i)  addr_q <= load_addr_i;
      else if (step_i)  addr_q <= addr_next;
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/brs_drive.sv
module brs_drive
   import brs_pkg::*;
(
   input  logic              sel_i,
   input  logic              oe_i,
   input  logic              we_i,
   input  logic              sync_i,
   input  seq_state_e        state_i,
   input  logic [7:0]        burst_lo_i,
   input  logic [7:0]        async_lo_i,
   output logic [WORD_W-1:0] dq_o,
   output logic              dq_oe_o,
   output logic              wait_o,
   output logic              wait_oe_o
);
   logic              drive;
   logic              in_data;
   logic [WORD_W-1:0] word;

   assign drive   = sel_i && oe_i && !we_i;
   assign in_data = (state_i == ST_DATA);

   always_comb begin
      if (!sync_i)      word = array_word(async_lo_i);
      else if (in_data) word = array_word(burst_lo_i);
      else              word = '0;
   end

   assign dq_oe_o   = drive;
   assign dq_o      = drive ? word : '0;
   assign wait_oe_o = drive;
   assign wait_o    = drive && sync_i && !in_data;
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
   import brs_pkg::*;
#(
   parameter int AW      = 8,
   parameter int LAT_W   = 3,
   parameter int LAT_RST = 3,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic              oe_i,
   input  logic              we_i,
   input  logic              sync_i,
   input  logic              start_i,
   input  logic [AW-1:0]     addr_i,
   input  logic              cfg_wr_i,
   input  logic              cfg_hold2_i,
   input  logic [LAT_W-1:0]  cfg_lat_i,
   input  logic [1:0]        cfg_wrap_i,
   output logic [WORD_W-1:0] dq_o,
   output logic              dq_oe_o,
   output logic              dv_o,
   output logic              wait_o,
   output logic              wait_oe_o
);
   localparam int LatMin = 2;
   localparam int LatMax = (1 << LAT_W) - 1;

   if (AW < 8 || AW > 16) begin : g_bad_aw
      $error("burst_read_seq: AW must lie in 8..16");
   end
   if (LAT_RST < LatMin || LAT_RST > LatMax) begin : g_bad_lat
      $error("burst_read_seq: LAT_RST outside the latency range");
   end

   logic             run;
   logic             cfg_hold2;
   logic [LAT_W-1:0] cfg_lat;
   logic [1:0]       cfg_wrap;
   seq_state_e       state;
   logic             step;
   logic [AW-1:0]    burst_addr;

   assign run = sel_i && sync_i;

   brs_cfg #(
      .LAT_W  (LAT_W),
      .LAT_MIN(LatMin),
      .LAT_RST(LAT_RST)
   ) u_cfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (cfg_wr_i),
      .hold2_i(cfg_hold2_i),
      .lat_i  (cfg_lat_i),
      .wrap_i (cfg_wrap_i),
      .hold2_o(cfg_hold2),
      .lat_o  (cfg_lat),
      .wrap_o (cfg_wrap)
   );

   brs_pacer #(.LAT_W(LAT_W)) u_pacer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .start_i(start_i),
      .hold2_i(cfg_hold2),
      .lat_i  (cfg_lat),
      .state_o(state),
      .dv_o   (dv_o),
      .step_o (step)
   );

   brs_addr #(.AW(AW), .WRAP_EN(WRAP_EN)) u_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (run && start_i),
      .load_addr_i(addr_i),
      .step_i     (step),
      .wrap_i     (cfg_wrap),
      .addr_o     (burst_addr)
   );

   brs_drive u_drive (
      .sel_i     (sel_i),
      .oe_i      (oe_i),
      .we_i      (we_i),
      .sync_i    (sync_i),
      .state_i   (state),
      .burst_lo_i(burst_addr[7:0]),
      .async_lo_i(addr_i[7:0]),
      .dq_o      (dq_o),
      .dq_oe_o   (dq_oe_o),
      .wait_o    (wait_o),
      .wait_oe_o (wait_oe_o)
   );
endmodule

// File: rtl/brs_checker.sv
module brs_checker (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        sel_i,
   input logic        oe_i,
   input logic        we_i,
   input logic        sync_i,
   input logic        start_i,
   input logic        hold2_i,
   input logic        dv_o,
   input logic        wait_o,
   input logic        wait_oe_o,
   input logic [15:0] dq_o,
   input logic        dq_oe_o
);
   p_start_no_dv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && sync_i && start_i) |=> !dv_o);

   p_hold_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dv_o && hold2_i && sel_i && sync_i && !start_i) |=> !dv_o);

   p_hold_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dv_o && !hold2_i && sel_i && sync_i && !start_i) |=> dv_o);

   p_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_i || !oe_i || we_i) |-> (!wait_oe_o && !dq_oe_o));

   p_wait_low_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dv_o |-> !wait_o);

   p_async_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync_i |-> !wait_o);

   p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i |=> !dv_o);

   p_dq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dq_oe_o |-> (dq_o == 16'h0000));

   p_wait_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wait_oe_o |-> !wait_o);

   p_async_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sync_i |=> !dv_o);
endmodule

bind burst_read_seq brs_checker u_brs_checker (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .sel_i    (sel_i),
   .oe_i     (oe_i),
   .we_i     (we_i),
   .sync_i   (sync_i),
   .start_i  (start_i),
   .hold2_i  (cfg_hold2),
   .dv_o     (dv_o),
   .wait_o   (wait_o),
   .wait_oe_o(wait_oe_o),
   .dq_o     (dq_o),
   .dq_oe_o  (dq_oe_o)
);

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        sel_i = 1'b0;
   logic        oe_i = 1'b0;
   logic        we_i = 1'b0;
   logic        sync_i = 1'b1;
   logic        start_i = 1'b0;
   logic [7:0]  addr_i = '0;
   logic        cfg_wr_i = 1'b0;
   logic        cfg_hold2_i = 1'b1;
   logic [2:0]  cfg_lat_i = 3'd3;
   logic [1:0]  cfg_wrap_i = 2'd0;
   logic [15:0] dq_o;
   logic        dq_oe_o;
   logic        dv_o;
   logic        wait_o;
   logic        wait_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk_i = ~clk_i;

   burst_read_seq i_burst_read_seq (
      .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .oe_i(oe_i), .we_i(we_i),
      .sync_i(sync_i), .start_i(start_i), .addr_i(addr_i), .cfg_wr_i(cfg_wr_i),
      .cfg_hold2_i(cfg_hold2_i), .cfg_lat_i(cfg_lat_i), .cfg_wrap_i(cfg_wrap_i),
      .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dv_o(dv_o), .wait_o(wait_o),
      .wait_oe_o(wait_oe_o)
   );

   function automatic logic [15:0] exp_word(input logic [7:0] a);
      return {~a, a};
   endfunction

   function automatic logic [7:0] exp_addr(input logic [7:0] a, input int j, input int enc);
      int len;
      len = (enc == 0) ? 256 : (4 << (enc - 1));
      return 8'((a & ~(len - 1)) | ((int'(a) + j) & (len - 1)));
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic write_cfg(input bit h2, input logic [2:0] lat, input logic [1:0] wr);
      @(negedge clk_i);
      cfg_wr_i = 1'b1; cfg_hold2_i = h2; cfg_lat_i = lat; cfg_wrap_i = wr;
      @(negedge clk_i);
      cfg_wr_i = 1'b0;
   endtask

   // Latch a at one edge, then check every clock up to n words.
   task automatic run_burst(input logic [7:0] a, input int lat, input int h,
                            input int enc, input int n, input string tg);
      @(negedge clk_i);
      sel_i = 1'b1; oe_i = 1'b1; we_i = 1'b0; sync_i = 1'b1; start_i = 1'b1; addr_i = a;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int k = 0; k < lat + n * h; k++) begin
         if (k > 0) @(negedge clk_i);
         if (k < lat) begin
            check(!dv_o && wait_o && wait_oe_o, {tg, " R2 R7 latency"},
                  {dv_o, wait_o, wait_oe_o}, 32'b011);
         end else begin
            int j;
            int ph;
            logic [15:0] w;
            j  = (k - lat) / h;
            ph = (k - lat) % h;
            w  = exp_word(exp_addr(a, j, enc));
            check(dv_o == (ph == 0) && !wait_o, {tg, " R3 R7 pacing"},
                  {dv_o, wait_o}, {ph == 0, 1'b0});
            check(dq_o == w, {tg, " R4 R5 data"}, dq_o, w);
         end
      end
      @(negedge clk_i);
      sel_i = 1'b0;
      @(negedge clk_i);
      check(!dv_o, {tg, " R9 end"}, dv_o, 0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      // R1 / R10: reset state, deselected
      check(!dv_o && !dq_oe_o && !wait_oe_o && dq_o == 0 && !wait_o, "R1 R10 reset",
            {dv_o, dq_oe_o, wait_oe_o, wait_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      sel_i = 1'b1; oe_i = 1'b1;
      #2;
      check(wait_o && wait_oe_o && !dv_o, "R7 sync idle wait", {wait_o, wait_oe_o, dv_o}, 3'b110);
      check(dq_o == 0 && dq_oe_o, "R1 idle data", dq_o, 0);

      // R1: defaults (hold two, latency 3, continuous) across the top of the space
      run_burst(8'hFE, 3, 2, 0, 5, "R1 default");

      // R2: latencies below the minimum act as 2
      write_cfg(1'b0, 3'd1, 2'd0);
      run_burst(8'h40, 2, 1, 0, 3, "R2 clamp1");
      write_cfg(1'b1, 3'd0, 2'd1);
      run_burst(8'h43, 2, 2, 1, 3, "R2 clamp0");

      // Sweep: hold x latency x wrap x start address
      for (int h2 = 0; h2 < 2; h2++)
         for (int lat = 2; lat < 8; lat++)
            for (int enc = 0; enc < 4; enc++)
               for (int ai = 0; ai < 3; ai++) begin
                  logic [7:0] a;
                  a = (ai == 0) ? 8'h00 : (ai == 1) ? 8'h0D : 8'hFB;
                  write_cfg(h2[0], 3'(lat), 2'(enc));
                  run_burst(a, lat, h2 + 1, enc, 18, "R3 R4 sweep");
               end

      // R6 / R10: drive enables over select, output enable and write
      for (int v = 0; v < 8; v++) begin
         bit drv;
         @(negedge clk_i);
         sel_i = v[0]; oe_i = v[1]; we_i = v[2]; sync_i = 1'b1;
         drv = v[0] && v[1] && !v[2];
         #2;
         check(wait_oe_o == drv && dq_oe_o == drv, "R6 enables",
               {wait_oe_o, dq_oe_o}, {drv, drv});
         check(wait_o == drv && dq_o == 0, "R10 quiet outputs", {wait_o, dq_o}, {drv, 16'h0});
      end
      we_i = 1'b0;

      // R8 / R11: asynchronous reads; a start strobe starts nothing
      for (int av = 0; av < 256; av += 37) begin
         @(negedge clk_i);
         sel_i = 1'b1; oe_i = 1'b1; sync_i = 1'b0; start_i = 1'b1; addr_i = 8'(av);
         #2;
         check(dq_o == exp_word(8'(av)) && !wait_o && wait_oe_o, "R8 async word",
               dq_o, exp_word(8'(av)));
         @(negedge clk_i);
         start_i = 1'b0;
         for (int c = 0; c < 8; c++) begin
            @(negedge clk_i);
            check(!dv_o && !wait_o, "R8 R11 no burst", {dv_o, wait_o}, 0);
         end
      end
      sync_i = 1'b1;

      // R9: abort on an edge that would issue the next word
      write_cfg(1'b0, 3'd2, 2'd0);
      @(negedge clk_i);
      sel_i = 1'b1; oe_i = 1'b1; start_i = 1'b1; addr_i = 8'h20;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (4) @(negedge clk_i);
      check(dv_o && dq_o == exp_word(8'h22), "R9 pre-abort word", dq_o, exp_word(8'h22));
      sel_i = 1'b0;
      @(negedge clk_i);
      check(!dv_o && !dq_oe_o && !wait_oe_o, "R9 aborted", {dv_o, dq_oe_o, wait_oe_o}, 0);
      sel_i = 1'b1;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk_i);
         check(!dv_o && wait_o && dq_o == 0, "R9 R7 stays idle", {dv_o, wait_o, dq_o}, 17'h10000);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule